// File: doc/BRIEF.md
# Down-Counting Compare Timer

A 32-bit timer that counts down once per prescaled tick and raises a sticky match flag when the count reaches a programmed compare value. Software reaches five word registers through a plain write-strobe and address port with a combinational read path. The five registers are control, status, reload value, compare value and the live count. The flag can drive an interrupt line through an enable bit, and each match can also toggle, clear or set an event pin.

At zero the counter either wraps to all ones or reloads from the reload register. A write to the reload register can be set up to force the count at once. Setting the run bit can be set up either to restart from the reload value or to resume from the held count. To schedule a one-shot event, software reads the live count, subtracts the delay modulo 2^32, and writes the result as the compare value. The match then fires after exactly that many ticks.

Top module: `cmp_down_timer`

## Requirements
- R1: After hardware reset the control, status, compare and counter registers read 0, the reload register reads 0xFFFFFFFF, and `irq_o` and `evt_pin_o` are 0.
- R2: Word registers sit at byte offsets control 0x00, status 0x04, reload 0x08, compare 0x0C and counter 0x10. Accesses with `bus_addr[1:0]` nonzero are ignored. Control keeps bits 0-15, 17 and 23:22, and reads 0 elsewhere apart from bit 16 during a soft reset. Writes to the counter offset have no effect.
- R3: With control bit 0 (run) set and prescale field bits 15:4 equal to N, the counter falls by one every N+1 clock cycles.
- R4: With control bit 3 (reload) clear, a tick at count 0 gives 0xFFFFFFFF.
- R5: With control bit 3 set, a tick at count 0 loads the reload register value.
- R6: When the run bit goes from 0 to 1 and control bit 1 is set, the counter takes the reload value on the next edge and the prescaler restarts. With bit 1 clear, counting resumes from the held value.
- R7: When control bit 17 is set, a reload-register write also places the written value in the counter at the same edge. When bit 17 is clear, the counter is untouched.
- R8: Status bit 0 sets on the edge at which a tick brings the counter equal to the compare register. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R9: `irq_o` is status bit 0 gated by control bit 2. Clearing bit 2 masks the line but keeps the flag.
- R10: On each match, control bits 23:22 act on the event pin: 0 disconnects it (`evt_pin_o` reads 0), 1 toggles it, 2 drives it low and 3 drives it high.
- R11: Writing compare = count - D (mod 2^32) sets the flag exactly D ticks later, including when the target lies past the wrap.
- R12: A control write with bit 16 set makes bit 16 read 1 for one cycle. At the next edge every register, the flag and the pin return to their R1 values, and bit 16 clears itself.
- R13: With run clear, the counter and the prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Compare interrupt |
| evt_pin_o | output | 1 | Event output pin |

## Verification
The counter assertions assume that only one of force-load, restart-load and tick decides the next count, with a fixed precedence. Soft reset outranks all three, so the checks are gated on those signals rather than assuming they never coincide. The flag assertions assume a match and a write-1 clear may land on the same edge, and they expect the set to win. The stimulus drives every bus write on the falling edge for exactly one cycle. It changes the run and prescale fields only between scenarios or at points where the expected count is re-read from the bus, so each tick count is predicted from a known start.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W  = 32;
  localparam int DIV_W  = 12;
  localparam int ADDR_W = 5;

  localparam int B_RUN  = 0;
  localparam int B_STL  = 1;
  localparam int B_IEN  = 2;
  localparam int B_RLD  = 3;
  localparam int B_DIV  = 4;
  localparam int B_SRST = 16;
  localparam int B_FRC  = 17;
  localparam int B_PIN  = 22;

  localparam logic [2:0] SEL_CTL = 3'd0;
  localparam logic [2:0] SEL_STS = 3'd1;
  localparam logic [2:0] SEL_LD  = 3'd2;
  localparam logic [2:0] SEL_CMP = 3'd3;
  localparam logic [2:0] SEL_CNT = 3'd4;

  localparam logic [REG_W-1:0] LOAD_RST = '1;

  typedef enum logic [1:0] {
    PIN_OFF  = 2'd0,
    PIN_TOG  = 2'd1,
    PIN_LOW  = 2'd2,
    PIN_HIGH = 2'd3
  } pin_mode_e;

  typedef struct packed {
    pin_mode_e        pin_mode;
    logic             force_ld;
    logic [DIV_W-1:0] div;
    logic             reload;
    logic             irq_en;
    logic             start_ld;
    logic             run;
  } ctl_t;

  function automatic ctl_t f_ctl_from_word(input logic [REG_W-1:0] w);
    ctl_t c;
    c.run      = w[B_RUN];
    c.start_ld = w[B_STL];
    c.irq_en   = w[B_IEN];
    c.reload   = w[B_RLD];
    c.div      = w[B_DIV +: DIV_W];
    c.force_ld = w[B_FRC];
    c.pin_mode = pin_mode_e'(w[B_PIN +: 2]);
    return c;
  endfunction

  function automatic logic [REG_W-1:0] f_ctl_to_word(input ctl_t c, input logic srst);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_RUN]          = c.run;
    w[B_STL]          = c.start_ld;
    w[B_IEN]          = c.irq_en;
    w[B_RLD]          = c.reload;
    w[B_DIV +: DIV_W] = c.div;
    w[B_SRST]         = srst;
    w[B_FRC]          = c.force_ld;
    w[B_PIN +: 2]     = c.pin_mode;
    return w;
  endfunction

  // Count after one tick: reload at zero when asked, else fall with wrap.
  function automatic logic [REG_W-1:0] f_next_count(input logic [REG_W-1:0] cnt,
                                                    input logic reload,
                                                    input logic [REG_W-1:0] load);
    if (cnt == '0 && reload) return load;
    return cnt - REG_W'(1);
  endfunction

  function automatic logic f_pin_next(input pin_mode_e m, input logic cur);
    case (m)
      PIN_TOG:  return ~cur;
      PIN_LOW:  return 1'b0;
      PIN_HIGH: return 1'b1;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pcnt_q;

  assign tick = run && !restart && !srst && (pcnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pcnt_q <= '0;
    else if (srst)        pcnt_q <= '0;
    else if (restart)     pcnt_q <= '0;
    else if (run) begin
      if (tick)           pcnt_q <= '0;
      else                pcnt_q <= pcnt_q + PW'(1);
    end
  end

  // R3: a divided tick is never followed directly by another one
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));

  // R13: an idle prescaler holds its phase
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart && !srst) |=> $stable(pcnt_q));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             tick,
  input  logic             start_load,
  input  logic             force_load,
  input  logic [REG_W-1:0] force_val,
  input  logic             reload,
  input  logic [REG_W-1:0] load_val,
  input  logic [REG_W-1:0] cmp_val,
  output logic [REG_W-1:0] cnt,
  output logic             match_evt
);
  logic [REG_W-1:0] cnt_q;
  logic [REG_W-1:0] cnt_step;
  logic             step_ok;

  assign cnt_step  = f_next_count(cnt_q, reload, load_val);
  assign step_ok   = tick && !srst && !force_load && !start_load;
  assign match_evt = step_ok && (cnt_step == cmp_val);
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (srst)       cnt_q <= '0;
    else if (force_load) cnt_q <= force_val;
    else if (start_load) cnt_q <= load_val;
    else if (step_ok)    cnt_q <= cnt_step;
  end

  // R3: ordinary step
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && cnt_q != '0) |=> cnt_q == $past(cnt_q) - REG_W'(1));

  // R4: free-running wrap
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && cnt_q == '0 && !reload) |=> cnt_q == '1);

  // R5: reload at zero
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && cnt_q == '0 && reload) |=> cnt_q == $past(load_val));

  // R6: restart takes the reload value
  p_start_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_load && !force_load && !srst) |=> cnt_q == $past(load_val));

  // R7: forced value lands at once
  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_load && !srst) |=> cnt_q == $past(force_val));

  // R13: nothing moves the count without a cause
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_load && !start_load && !srst) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_outpin.sv
module tmr_outpin
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      srst,
  input  logic      match_evt,
  input  pin_mode_e mode,
  output logic      pin_o
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pin_q <= 1'b0;
    else if (srst)      pin_q <= 1'b0;
    else if (match_evt) pin_q <= f_pin_next(mode, pin_q);
  end

  assign pin_o = (mode != PIN_OFF) && pin_q;

  // R10: set and clear modes
  p_pin_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !srst && mode == PIN_HIGH) |=> pin_q);
  p_pin_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !srst && mode == PIN_LOW) |=> !pin_q);
  p_pin_tog_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !srst && mode == PIN_TOG) |=> pin_q != $past(pin_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  cnt,
  input  logic              match_evt,
  output ctl_t              ctl,
  output logic              srst,
  output logic [REG_W-1:0]  load_val,
  output logic [REG_W-1:0]  cmp_val,
  output logic              start_load,
  output logic              force_load,
  output logic              flag
);
  ctl_t             ctl_q;
  logic             srst_q;
  logic             run_q;
  logic             flag_q;
  logic [REG_W-1:0] load_q;
  logic [REG_W-1:0] cmp_q;
  logic             aligned;
  logic [2:0]       sel;
  logic             wr_ctl, wr_sts, wr_ld, wr_cmp;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign sel     = bus_addr[4:2];
  assign wr_ctl  = bus_we && aligned && sel == SEL_CTL && !srst_q;
  assign wr_sts  = bus_we && aligned && sel == SEL_STS && !srst_q;
  assign wr_ld   = bus_we && aligned && sel == SEL_LD  && !srst_q;
  assign wr_cmp  = bus_we && aligned && sel == SEL_CMP && !srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      srst_q <= 1'b0;
      run_q  <= 1'b0;
      load_q <= LOAD_RST;
      cmp_q  <= '0;
    end else if (srst_q) begin
      ctl_q  <= '0;
      srst_q <= 1'b0;
      run_q  <= 1'b0;
      load_q <= LOAD_RST;
      cmp_q  <= '0;
    end else begin
      run_q <= ctl_q.run;
      if (wr_ctl) begin
        if (bus_wdata[B_SRST]) srst_q <= 1'b1;
        else                   ctl_q  <= f_ctl_from_word(bus_wdata);
      end
      if (wr_ld)  load_q <= bus_wdata;
      if (wr_cmp) cmp_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      flag_q <= 1'b0;
    else if (srst_q)                 flag_q <= 1'b0;
    else if (match_evt)              flag_q <= 1'b1;
    else if (wr_sts && bus_wdata[0]) flag_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (sel)
        SEL_CTL: bus_rdata = f_ctl_to_word(ctl_q, srst_q);
        SEL_STS: bus_rdata = {{(REG_W-1){1'b0}}, flag_q};
        SEL_LD:  bus_rdata = load_q;
        SEL_CMP: bus_rdata = cmp_q;
        SEL_CNT: bus_rdata = cnt;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign ctl        = ctl_q;
  assign srst       = srst_q;
  assign load_val   = load_q;
  assign cmp_val    = cmp_q;
  assign flag       = flag_q;
  assign start_load = ctl_q.run && !run_q && ctl_q.start_ld && !srst_q;
  assign force_load = wr_ld && ctl_q.force_ld;

  // R8: a match always leaves the flag set
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !srst_q) |=> flag_q);

  // R9: only a write-1 or soft reset drops the flag
  p_flag_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !srst_q && !(wr_sts && bus_wdata[0])) |=> flag_q);

  // R12: soft reset lasts one cycle and restores defaults
  p_srst_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
  p_srst_dflt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (load_q == LOAD_RST && cmp_q == '0 && !flag_q && ctl_q == '0));
endmodule

// File: rtl/cmp_down_timer.sv
module cmp_down_timer
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        evt_pin_o
);
  ctl_t             ctl;
  logic             srst;
  logic [REG_W-1:0] load_val;
  logic [REG_W-1:0] cmp_val;
  logic [REG_W-1:0] cnt;
  logic             start_load;
  logic             force_load;
  logic             flag;
  logic             tick;
  logic             match_evt;

  tmr_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cnt        (cnt),
    .match_evt  (match_evt),
    .ctl        (ctl),
    .srst       (srst),
    .load_val   (load_val),
    .cmp_val    (cmp_val),
    .start_load (start_load),
    .force_load (force_load),
    .flag       (flag)
  );

  tmr_prescaler #(.PW(DIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst),
    .run     (ctl.run),
    .restart (start_load),
    .div     (ctl.div),
    .tick    (tick)
  );

  tmr_count_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst       (srst),
    .tick       (tick),
    .start_load (start_load),
    .force_load (force_load),
    .force_val  (bus_wdata),
    .reload     (ctl.reload),
    .load_val   (load_val),
    .cmp_val    (cmp_val),
    .cnt        (cnt),
    .match_evt  (match_evt)
  );

  tmr_outpin u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (srst),
    .match_evt (match_evt),
    .mode      (ctl.pin_mode),
    .pin_o     (evt_pin_o)
  );

  assign irq_o = flag && ctl.irq_en;

  // R9: a masked line never rises
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.irq_en) |-> !irq_o);
endmodule

// File: tb/cmp_down_timer_tb_top.sv
module cmp_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        evt_pin_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [4:0] A_CTL = 5'h00, A_STS = 5'h04, A_LD = 5'h08,
                         A_CMP = 5'h0C, A_CNT = 5'h10;
  localparam logic [31:0] C_RUN = 32'h1, C_STL = 32'h2, C_IEN = 32'h4,
                          C_RLD = 32'h8, C_SRST = 32'h1_0000, C_FRC = 32'h2_0000;

  always #4 clk = ~clk;

  cmp_down_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .evt_pin_o(evt_pin_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic nwait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl_div(input int n);
    return 32'(n) << 4;
  endfunction

  function automatic logic [31:0] ctl_pin(input int m);
    return 32'(m) << 22;
  endfunction

  task automatic soft_reset();
    wr(A_CTL, C_SRST);
    nwait(1);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(A_CTL, v); check("R1 ctl", v, 32'h0);
    rd(A_STS, v); check("R1 sts", v, 32'h0);
    rd(A_LD, v);  check("R1 load", v, 32'hFFFF_FFFF);
    rd(A_CMP, v); check("R1 cmp", v, 32'h0);
    rd(A_CNT, v); check("R1 cnt", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 pin", {31'b0, evt_pin_o}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_CTL, 32'hFFFE_FFFE);
    rd(A_CTL, v); check("R2 ctl mask", v, 32'h00C2_FFFE);
    soft_reset();
    wr(A_CMP, 32'hA5A5_0F0F);
    rd(A_CMP, v); check("R2 cmp rw", v, 32'hA5A5_0F0F);
    wr(5'h09, 32'h1111_2222);
    rd(A_LD, v); check("R2 unaligned ignored", v, 32'hFFFF_FFFF);
    wr(A_CNT, 32'hDEAD_BEEF);
    rd(A_CNT, v); check("R2 counter write ignored", v, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    soft_reset();
    wr(A_LD, 32'd100);
    wr(A_CTL, C_RUN | C_STL | ctl_div(3));
    nwait(1); rd(A_CNT, v); check("R3 start value", v, 32'd100);
    nwait(3); rd(A_CNT, v); check("R3 before tick", v, 32'd100);
    nwait(1); rd(A_CNT, v); check("R3 first tick", v, 32'd99);
    nwait(4); rd(A_CNT, v); check("R3 second tick", v, 32'd98);
  endtask

  task automatic t_wrap_reload(input bit rl);
    logic [31:0] v;
    soft_reset();
    wr(A_LD, 32'd2);
    wr(A_CTL, C_RUN | C_STL | (rl ? C_RLD : 32'h0));
    nwait(1); rd(A_CNT, v); check(rl ? "R5 start" : "R4 start", v, 32'd2);
    nwait(2); rd(A_CNT, v); check(rl ? "R5 zero" : "R4 zero", v, 32'd0);
    nwait(1); rd(A_CNT, v);
    if (rl) check("R5 reload at zero", v, 32'd2);
    else    check("R4 wrap to ones", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_start_modes();
    logic [31:0] v, held;
    soft_reset();
    wr(A_LD, 32'd50);
    wr(A_CTL, C_RUN | C_STL);
    nwait(1); rd(A_CNT, v); check("R6 restart loads", v, 32'd50);
    nwait(1); rd(A_CNT, v); check("R6 counting", v, 32'd49);
    wr(A_CTL, 32'h0);
    rd(A_CNT, held);
    nwait(5); rd(A_CNT, v); check("R13 idle hold", v, held);
    wr(A_CTL, C_RUN);
    nwait(1); rd(A_CNT, v); check("R6 resume from held", v, held - 32'd1);
    wr(A_CTL, C_STL);
    wr(A_CTL, C_RUN | C_STL);
    nwait(1); rd(A_CNT, v); check("R6 restart again", v, 32'd50);
  endtask

  task automatic t_force();
    logic [31:0] v;
    soft_reset();
    wr(A_CTL, C_FRC);
    wr(A_LD, 32'h0000_1234);
    rd(A_CNT, v); check("R7 forced", v, 32'h0000_1234);
    wr(A_CTL, 32'h0);
    wr(A_LD, 32'h0000_0055);
    rd(A_CNT, v); check("R7 no force", v, 32'h0000_1234);
    rd(A_LD, v);  check("R7 load stored", v, 32'h0000_0055);
  endtask

  task automatic t_match_flag();
    logic [31:0] v, start;
    soft_reset();
    wr(A_CTL, C_FRC);
    wr(A_LD, 32'd10);
    rd(A_CNT, start);
    wr(A_CMP, start - 32'd3);
    wr(A_CTL, C_RUN | C_IEN | C_FRC);
    nwait(2); rd(A_STS, v); check("R11 not yet", v, 32'h0);
    nwait(1); rd(A_STS, v); check("R8 flag on match", v, 32'h1);
    check("R9 irq with enable", {31'b0, irq_o}, 32'h1);
    wr(A_CTL, C_IEN);
    wr(A_STS, 32'h0);
    rd(A_STS, v); check("R8 write0 keeps", v, 32'h1);
    wr(A_STS, 32'h1);
    rd(A_STS, v); check("R8 write1 clears", v, 32'h0);
    check("R9 irq drops", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_oneshot_wrap();
    logic [31:0] v, start;
    soft_reset();
    wr(A_CTL, C_FRC);
    wr(A_LD, 32'd1);
    rd(A_CNT, start);
    wr(A_CMP, start - 32'd3);
    rd(A_CMP, v); check("R11 wrapped target", v, 32'hFFFF_FFFE);
    wr(A_CTL, C_RUN);
    nwait(2); rd(A_STS, v); check("R11 wrap not yet", v, 32'h0);
    nwait(1); rd(A_STS, v); check("R11 wrap match", v, 32'h1);
  endtask

  task automatic t_irq_mask();
    logic [31:0] v;
    soft_reset();
    wr(A_CTL, C_FRC);
    wr(A_LD, 32'd5);
    wr(A_CMP, 32'd4);
    wr(A_CTL, C_RUN | C_FRC);
    nwait(1);
    rd(A_STS, v); check("R9 flag while masked", v, 32'h1);
    check("R9 masked irq", {31'b0, irq_o}, 32'h0);
    wr(A_CTL, C_IEN);
    check("R9 unmask shows irq", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_pin();
    soft_reset();
    wr(A_LD, 32'd1);
    wr(A_CMP, 32'd0);
    wr(A_CTL, C_RUN | C_STL | C_RLD | ctl_pin(1));
    nwait(1); check("R10 toggle before", {31'b0, evt_pin_o}, 32'h0);
    nwait(1); check("R10 toggle up", {31'b0, evt_pin_o}, 32'h1);
    nwait(1); check("R10 toggle hold", {31'b0, evt_pin_o}, 32'h1);
    nwait(1); check("R10 toggle down", {31'b0, evt_pin_o}, 32'h0);
    wr(A_CTL, C_RUN | C_RLD | ctl_pin(3));
    nwait(4); check("R10 set mode", {31'b0, evt_pin_o}, 32'h1);
    wr(A_CTL, C_RUN | C_RLD | ctl_pin(2));
    nwait(4); check("R10 clear mode", {31'b0, evt_pin_o}, 32'h0);
    wr(A_CTL, C_RUN | C_RLD | ctl_pin(3));
    nwait(4); check("R10 set again", {31'b0, evt_pin_o}, 32'h1);
    wr(A_CTL, C_RUN | C_RLD | ctl_pin(0));
    check("R10 disconnected", {31'b0, evt_pin_o}, 32'h0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(A_LD, 32'd7);
    wr(A_CMP, 32'd9);
    wr(A_CTL, C_RUN | C_IEN | ctl_pin(3));
    wr(A_CTL, C_SRST);
    rd(A_CTL, v); check("R12 bit visible", v, 32'h00C1_0005);
    nwait(1);
    rd(A_CTL, v); check("R12 ctl cleared", v, 32'h0);
    rd(A_LD, v);  check("R12 load default", v, 32'hFFFF_FFFF);
    rd(A_CMP, v); check("R12 cmp default", v, 32'h0);
    rd(A_CNT, v); check("R12 cnt default", v, 32'h0);
    rd(A_STS, v); check("R12 sts default", v, 32'h0);
    check("R12 pin default", {31'b0, evt_pin_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nwait(1);
    t_reset_state();
    t_regmap();
    t_prescale();
    t_wrap_reload(1'b0);
    t_wrap_reload(1'b1);
    t_start_modes();
    t_force();
    t_match_flag();
    t_oneshot_wrap();
    t_irq_mask();
    t_pin();
    t_soft_reset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule